// File: doc/BRIEF.md
# Tiled Command Dispatch Scheduler

This block sits between a control processor and the execution engines of one processing element. Commands arrive on a valid/ready port, each carrying a kind, a command identifier and a tile-count field. The block sorts every command as simple or composite. A simple command is handed straight to one engine port: DMA, GEMM or math. A composite command is queued in a single pending FIFO. A feeder drains that FIFO one command at a time and emits one token per tile into the first pipeline stage.

The block does not follow a tile from one stage to the next. Engines and the final pipeline stage report finished work on a completion-event input that carries a command identifier. An in-flight table counts those events per identifier. When the count reaches the command's total, the block pushes the identifier into a completion-record FIFO. Records leave that FIFO in the order in which commands finished. The identifier becomes free again once its record has been taken.

Top module: `tile_dispatch_sched`

## Requirements
- R1: A simple command goes to exactly one engine port, chosen by cmd_kind: 0 (DMA read) and 1 (DMA write) go to port bit 0, 2 (GEMM) goes to bit 1, and 3 (math) goes to bit 2. eng_dma_wr is high only for kind 1. A simple command is accepted only when its engine's ready is high.
- R2: A command with cmd_kind bit 2 set is composite with cmd_tiles+1 tiles. Its tokens carry its identifier and tile_id values 0, 1, 2 and so on, up to cmd_tiles, one per accepted token, with tile_id restarting at 0 for each command.
- R3: Composite commands are fed in arrival order. Every tile of one command is emitted before any tile of the next command.
- R4: While tok_ready is low, intake continues. A composite command is still accepted while the pending FIFO has room, and a simple command is still accepted while its engine is ready.
- R5: A simple command counts as one sub-command, and a composite command counts as cmd_tiles+1 sub-commands. A completion record with the command identifier appears once the matching number of done events has been received, and not before.
- R6: A command produces exactly one completion record. Its identifier is free for a new command only after that record has been taken with cpl_valid and cpl_ready.
- R7: A done event for an identifier that is not in flight sets err_sticky. The flag stays set until reset, and the event changes no count and produces no record.
- R8: Completion records leave in the order in which commands finished, regardless of submission order.
- R9: A command whose identifier is still in flight or awaiting its record is held: cmd_ready is low and no engine valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_kind | input | 3 | 0 DMA read, 1 DMA write, 2 GEMM, 3 math, bit 2 set means composite |
| cmd_id | input | ID_W | Command identifier |
| cmd_tiles | input | TILE_W | Tile count minus one (composite only) |
| eng_valid | output | 3 | Per-engine dispatch valid (bit 0 DMA, bit 1 GEMM, bit 2 math) |
| eng_ready | input | 3 | Per-engine queue ready |
| eng_id | output | ID_W | Identifier of the dispatched command |
| eng_dma_wr | output | 1 | DMA direction, high for write |
| tok_valid | output | 1 | Tile token offered to the first stage |
| tok_ready | input | 1 | First stage accepts the token |
| tok_cmd_id | output | ID_W | Identifier of the token's command |
| tok_tile_id | output | TILE_W | Tile index within the command |
| done_valid | input | 1 | One sub-command or tile finished |
| done_id | input | ID_W | Identifier of the finished work |
| cpl_valid | output | 1 | Completion record available |
| cpl_ready | input | 1 | Completion record taken |
| cpl_id | output | ID_W | Identifier of the completed command |
| err_sticky | output | 1 | Done event seen for an identifier not in flight |

## Verification
The bench builds the block with ID_W=3, TILE_W=3 and a pending depth of 4. With these values every simple kind can be dispatched and the full range of tile counts, 1 to 8, can be swept. Each count is run through the token stream and the completion count, and the eight identifiers are cycled. The small identifier space makes it cheap to fill several in-flight commands, hold the first stage stalled, finish them out of submission order, and reach the busy-identifier hold and the stray-done error.

// File: rtl/tds_pkg.sv
package tds_pkg;
  localparam int NUM_ENG = 3;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_BUSY = 2'd1,
    SLOT_DONE = 2'd2
  } slot_e;

  // Kind bit 2 marks a composite command.
  function automatic logic kind_is_composite(input logic [2:0] kind);
    return kind[2];
  endfunction

  // One-hot engine select for a simple kind; zero for composite kinds.
  function automatic logic [NUM_ENG-1:0] kind_engine(input logic [2:0] kind);
    if (kind[2]) return '0;
    case (kind[1:0])
      2'd0, 2'd1: return 3'b001;
      2'd2:       return 3'b010;
      default:    return 3'b100;
    endcase
  endfunction
endpackage

// File: rtl/tds_fifo.sv
module tds_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign head  = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) begin
        mem[wptr[AW-1:0]] <= push_data;
        wptr <= wptr + 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
    end
  end

  // R6: neither the pending queue nor the record queue is written when full
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tds_tile_feeder.sv
module tds_tile_feeder #(
  parameter int ID_W   = 3,
  parameter int TILE_W = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq,
  input  logic [ID_W-1:0]   enq_id,
  input  logic [TILE_W-1:0] enq_last,
  output logic              pend_full,
  output logic              tok_valid,
  input  logic              tok_ready,
  output logic [ID_W-1:0]   tok_cmd_id,
  output logic [TILE_W-1:0] tok_tile_id
);
  localparam int PW = ID_W + TILE_W;

  logic [PW-1:0]     pend_head;
  logic              pend_empty, pend_pop;
  logic              busy;
  logic [ID_W-1:0]   cur_id;
  logic [TILE_W-1:0] cur_last, tile;
  logic              tok_fire, tok_last;

  tds_fifo #(.W(PW), .DEPTH(DEPTH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .push(enq), .push_data({enq_id, enq_last}),
    .pop(pend_pop), .head(pend_head),
    .empty(pend_empty), .full(pend_full)
  );

  assign tok_valid   = busy;
  assign tok_cmd_id  = cur_id;
  assign tok_tile_id = tile;
  assign tok_fire    = tok_valid && tok_ready;
  assign tok_last    = tok_fire && (tile == cur_last);
  // A new command is loaded only once the current one has emitted its last tile.
  assign pend_pop    = !pend_empty && (!busy || tok_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_id   <= '0;
      cur_last <= '0;
      tile     <= '0;
    end else if (pend_pop) begin
      busy     <= 1'b1;
      cur_id   <= pend_head[PW-1:TILE_W];
      cur_last <= pend_head[TILE_W-1:0];
      tile     <= '0;
    end else if (tok_last) begin
      busy <= 1'b0;
    end else if (tok_fire) begin
      tile <= tile + 1'b1;
    end
  end

  // R2: consecutive tiles of one command step by one
  p_tile_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_fire && !tok_last |=> tok_valid && tok_tile_id == $past(tok_tile_id) + 1'b1
                               && tok_cmd_id == $past(tok_cmd_id));
  // R3: a command starts at tile 0 after the previous one ends
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_last && !pend_empty |=> tok_valid && tok_tile_id == '0);
  // R4: a stalled token holds still
  p_tok_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_ready |=> tok_valid && $stable(tok_tile_id) && $stable(tok_cmd_id));
endmodule

// File: rtl/tds_cpl_tracker.sv
module tds_cpl_tracker
  import tds_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  query_id,
  output logic             query_free,
  input  logic             alloc_valid,
  input  logic [ID_W-1:0]  alloc_id,
  input  logic [CNT_W-1:0] alloc_total,
  input  logic             done_valid,
  input  logic [ID_W-1:0]  done_id,
  output logic             cpl_valid,
  input  logic             cpl_ready,
  output logic [ID_W-1:0]  cpl_id,
  output logic             err_sticky
);
  localparam int N = 1 << ID_W;

  slot_e            st  [N];
  logic [CNT_W-1:0] tot [N];
  logic [CNT_W-1:0] cnt [N];

  logic done_hit, done_last, done_bad, cpl_pop, cpl_empty, cpl_full;

  function automatic logic reaches_total(input logic [CNT_W-1:0] c,
                                         input logic [CNT_W-1:0] t);
    return (c + CNT_W'(1)) == t;
  endfunction

  assign query_free = (st[query_id] == SLOT_FREE);
  assign done_hit   = done_valid && (st[done_id] == SLOT_BUSY);
  assign done_last  = done_hit && reaches_total(cnt[done_id], tot[done_id]);
  assign done_bad   = done_valid && !done_hit;
  assign cpl_valid  = !cpl_empty;
  assign cpl_pop    = cpl_valid && cpl_ready;

  tds_fifo #(.W(ID_W), .DEPTH(N)) u_cplq (
    .clk(clk), .rst_n(rst_n),
    .push(done_last), .push_data(done_id),
    .pop(cpl_pop), .head(cpl_id),
    .empty(cpl_empty), .full(cpl_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_sticky <= 1'b0;
      for (int i = 0; i < N; i++) begin
        st[i]  <= SLOT_FREE;
        tot[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      if (done_bad) err_sticky <= 1'b1;
      for (int i = 0; i < N; i++) begin
        if (alloc_valid && alloc_id == ID_W'(i)) begin
          st[i]  <= SLOT_BUSY;
          tot[i] <= alloc_total;
          cnt[i] <= '0;
        end else if (done_hit && done_id == ID_W'(i)) begin
          if (done_last) st[i] <= SLOT_DONE;
          else           cnt[i] <= cnt[i] + 1'b1;
        end else if (cpl_pop && cpl_id == ID_W'(i)) begin
          st[i] <= SLOT_FREE;
        end
      end
    end
  end

  // R5: the last expected done event yields a record next cycle
  p_record_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_last |=> cpl_valid);
  // R7: a stray done event raises the error flag
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_bad |=> err_sticky);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  // R6: the record queue holds at most one entry per identifier
  p_cplq_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_full |-> !done_last);
endmodule

// File: rtl/tile_dispatch_sched.sv
module tile_dispatch_sched
  import tds_pkg::*;
#(
  parameter int ID_W       = 3,
  parameter int TILE_W     = 3,
  parameter int PEND_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_kind,
  input  logic [ID_W-1:0]     cmd_id,
  input  logic [TILE_W-1:0]   cmd_tiles,
  output logic [NUM_ENG-1:0]  eng_valid,
  input  logic [NUM_ENG-1:0]  eng_ready,
  output logic [ID_W-1:0]     eng_id,
  output logic                eng_dma_wr,
  output logic                tok_valid,
  input  logic                tok_ready,
  output logic [ID_W-1:0]     tok_cmd_id,
  output logic [TILE_W-1:0]   tok_tile_id,
  input  logic                done_valid,
  input  logic [ID_W-1:0]     done_id,
  output logic                cpl_valid,
  input  logic                cpl_ready,
  output logic [ID_W-1:0]     cpl_id,
  output logic                err_sticky
);
  localparam int CNT_W = TILE_W + 1;

  logic               is_comp, id_free, pend_full, accept, comp_enq;
  logic [NUM_ENG-1:0] sel;
  logic [CNT_W-1:0]   total;

  function automatic logic [CNT_W-1:0] sub_total(input logic comp,
                                                 input logic [TILE_W-1:0] field);
    return comp ? (CNT_W'(field) + CNT_W'(1)) : CNT_W'(1);
  endfunction

  assign is_comp    = kind_is_composite(cmd_kind);
  assign sel        = kind_engine(cmd_kind);
  assign total      = sub_total(is_comp, cmd_tiles);
  assign cmd_ready  = id_free && (is_comp ? !pend_full : |(sel & eng_ready));
  assign accept     = cmd_valid && cmd_ready;
  assign comp_enq   = accept && is_comp;
  assign eng_valid  = (cmd_valid && id_free) ? sel : '0;
  assign eng_id     = cmd_id;
  assign eng_dma_wr = (cmd_kind == 3'd1);

  tds_tile_feeder #(.ID_W(ID_W), .TILE_W(TILE_W), .DEPTH(PEND_DEPTH)) u_feed (
    .clk(clk), .rst_n(rst_n),
    .enq(comp_enq), .enq_id(cmd_id), .enq_last(cmd_tiles),
    .pend_full(pend_full),
    .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_cmd_id(tok_cmd_id), .tok_tile_id(tok_tile_id)
  );

  tds_cpl_tracker #(.ID_W(ID_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .query_id(cmd_id), .query_free(id_free),
    .alloc_valid(accept), .alloc_id(cmd_id), .alloc_total(total),
    .done_valid(done_valid), .done_id(done_id),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_id(cpl_id),
    .err_sticky(err_sticky)
  );

  // R1: at most one engine port is raised
  p_onehot_dispatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid));
  // R1: composite commands never reach an engine port
  p_comp_no_engine_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_comp |-> eng_valid == '0);
  // R4: a stalled first stage does not block simple intake
  p_intake_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !is_comp && id_free && (|(sel & eng_ready)) && tok_valid && !tok_ready
      |-> cmd_ready);
  // R9: an identifier in flight is held off
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !id_free |-> !cmd_ready && eng_valid == '0);
endmodule

// File: tb/tb_tile_dispatch_sched.sv
module tb_tile_dispatch_sched;
  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0, tok_ready = 0, done_valid = 0, cpl_ready = 0;
  logic [2:0] cmd_kind = 0, eng_ready = 0;
  logic [2:0] cmd_id = 0, cmd_tiles = 0, done_id = 0;
  logic       cmd_ready, eng_dma_wr, tok_valid, cpl_valid, err_sticky;
  logic [2:0] eng_valid, eng_id, tok_cmd_id, tok_tile_id, cpl_id;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tile_dispatch_sched #(.ID_W(3), .TILE_W(3), .PEND_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_id(cmd_id), .cmd_tiles(cmd_tiles),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_id(eng_id), .eng_dma_wr(eng_dma_wr),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_cmd_id(tok_cmd_id),
    .tok_tile_id(tok_tile_id), .done_valid(done_valid), .done_id(done_id),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_id(cpl_id), .err_sticky(err_sticky)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_engine(input int kind);
    return (kind < 2) ? 1 : (kind == 2) ? 2 : 4;
  endfunction

  task automatic send(input int kind, input int id, input int tiles);
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 3'(kind); cmd_id = 3'(id); cmd_tiles = 3'(tiles);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  task automatic done_ev(input int id);
    @(negedge clk);
    done_valid = 1; done_id = 3'(id);
    @(posedge clk); #1 done_valid = 0;
  endtask

  task automatic pop_cpl(input int exp, input string req);
    @(negedge clk);
    chk(cpl_valid && cpl_id == 3'(exp), req, cpl_valid ? int'(cpl_id) : -1, exp);
    cpl_ready = 1;
    @(posedge clk); #1 cpl_ready = 0;
  endtask

  task automatic take_tok(input int id, input int tile, input string req);
    @(negedge clk);
    while (!tok_valid) @(negedge clk);
    chk(tok_cmd_id == 3'(id) && tok_tile_id == 3'(tile), req,
        int'(tok_cmd_id) * 8 + int'(tok_tile_id), id * 8 + tile);
    tok_ready = 1;
    @(posedge clk); #1 tok_ready = 0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!tok_valid && !cpl_valid && !err_sticky && eng_valid == 0, "reset", 1, 0);

    // R1: each simple kind reaches its engine, DMA write flagged
    eng_ready = 3'b111;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmd_valid = 1; cmd_kind = 3'(k); cmd_id = 3'(k); cmd_tiles = 0;
      #1;
      chk(int'(eng_valid) == exp_engine(k) && cmd_ready, "R1 engine", int'(eng_valid), exp_engine(k));
      chk(eng_dma_wr == (k == 1) && eng_id == 3'(k), "R1 dma dir", int'(eng_dma_wr), int'(k == 1));
      @(posedge clk); #1 cmd_valid = 0;
    end
    // R1: engine not ready holds the command
    eng_ready = 3'b101;
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 3'd2; cmd_id = 3'd4;
    #1 chk(!cmd_ready, "R1 engine backpressure", int'(cmd_ready), 0);
    @(negedge clk); cmd_valid = 0;
    eng_ready = 3'b111;
    // R5/R8: finish in reverse order, records follow finish order
    for (int k = 3; k >= 0; k--) done_ev(k);
    for (int k = 3; k >= 0; k--) pop_cpl(k, "R8 record order");

    // R2/R5: sweep every tile count
    for (int n = 1; n <= 8; n++) begin
      int id;
      id = n % 8;
      send(4, id, n - 1);
      for (int t = 0; t < n; t++) take_tok(id, t, "R2 tile sequence");
      @(negedge clk);
      chk(!tok_valid, "R2 no extra token", int'(tok_valid), 0);
      for (int t = 0; t < n; t++) begin
        @(negedge clk);
        chk(!cpl_valid, "R5 no early record", int'(cpl_valid), 0);
        done_ev(id);
      end
      pop_cpl(id, "R5 record after last tile");
      @(negedge clk);
      chk(!cpl_valid, "R6 single record", int'(cpl_valid), 0);
    end

    // R3/R4/R9: stalled first stage, two composites and a simple one
    tok_ready = 0;
    send(4, 1, 2);
    send(5, 2, 1);
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 3'd2; cmd_id = 3'd3;
    #1 chk(cmd_ready && eng_valid == 3'b010, "R4 intake during stall", int'(cmd_ready), 1);
    @(posedge clk); #1 cmd_valid = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 3'd0; cmd_id = 3'd1;
    #1 chk(!cmd_ready && eng_valid == 0, "R9 busy id held", int'(cmd_ready), 0);
    @(negedge clk); cmd_valid = 0;
    for (int t = 0; t < 3; t++) take_tok(1, t, "R3 first command tiles");
    for (int t = 0; t < 2; t++) take_tok(2, t, "R3 second command tiles");
    done_ev(2); done_ev(2);
    done_ev(3);
    done_ev(1); done_ev(1); done_ev(1);
    pop_cpl(2, "R8 order first");
    pop_cpl(3, "R8 order second");
    pop_cpl(1, "R8 order third");

    // R6: identifier reusable after record taken
    send(0, 1, 0);
    chk(1, "R6 reuse", 1, 1);
    done_ev(1);
    pop_cpl(1, "R6 reused id record");

    // R7: stray done
    @(negedge clk);
    chk(!err_sticky, "R7 clear before", int'(err_sticky), 0);
    done_ev(6);
    @(negedge clk);
    chk(err_sticky && !cpl_valid, "R7 stray done", int'(err_sticky), 1);
    repeat (3) @(negedge clk);
    chk(err_sticky, "R7 sticky", int'(err_sticky), 1);
    send(4, 6, 1);
    take_tok(6, 0, "R7 token 0");
    take_tok(6, 1, "R7 token 1");
    done_ev(6);
    @(negedge clk);
    chk(!cpl_valid, "R7 count untouched by stray", int'(cpl_valid), 0);
    done_ev(6);
    pop_cpl(6, "R7 record after full count");

    finish_up();
  end
endmodule